// File: doc/BRIEF.md
# Open-Drain Two-Wire Pad Control Register

This block gives software direct control of two open-drain pads that carry a two-wire serial bus. Line 0 is the clock pad and line 1 is the data pad. Software drives the protocol one bus edge at a time by writing the register. Each line has a direction field and an output-value field. A write-enable bit sits beside each of those fields in the same word, so one write can change a single field and leave every other field as it was.

A line is pulled low only when its direction is output and its value is 0. In every other setting the pad is released, and an external resistor pulls the line high. The pad is never driven high. The level on each pin passes through a synchroniser and can be read back in the same word, whatever the direction setting. Each line also has a pull-up-disable bit. This bit is loaded on every write, so software keeps its value by writing it back.

Each line owns an 8-bit group of the word, starting at bit 8*line. Within a group, bit 0 is the direction write-enable and bit 1 is the direction (1 = output, 0 = input/released). Bit 2 is the value write-enable and bit 3 is the value. Bit 4 is the read-only synchronised pin level. Bit 5 is the pull-up disable. Bits 6 and 7 are reserved.

Top module: `odpad_ctl`

## Requirements
- R1: After a synchronous reset every line is an input with value 0 and pull-up disable 0. `rd_data` reads all zero (with the pins low at reset), and `pad_oe` and `pad_pu_dis` are 0.
- R2: On a write (`wr_en` high at a clock edge), a line's direction bit (group bit 1) takes the written bit only if group bit 0 is 1. Otherwise it keeps its old value.
- R3: On a write, a line's value bit (group bit 3) takes the written bit only if group bit 2 is 1. Otherwise it keeps its old value.
- R4: `pad_oe[i]` is 1 (pull line i low) exactly when line i has direction output and value 0. It follows the register from the edge that loads the write.
- R5: Group bit 4 reads the level of `pad_in[i]` as sampled two clock edges earlier, whatever the direction setting. Writes to bit 4 have no effect.
- R6: Every write loads group bit 5 into line i's pull-up disable. That value appears on `pad_pu_dis[i]` and reads back in bit 5.
- R7: The write-enable bits (group bits 0 and 2) and the reserved bits (6, 7) always read 0.
- R8: A cycle with `wr_en` low changes no field, no `pad_oe` and no `pad_pu_dis`, whatever is on `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8*LINES | Written word, one 8-bit group per line |
| rd_data | output | 8*LINES | Register readback including synchronised pin levels |
| pad_in | input | LINES | Pin levels from the pads |
| pad_oe | output | LINES | Pull-low enable per pad (pad output value is fixed at 0) |
| pad_pu_dis | output | LINES | Pull-up disable per pad |

## Verification
A write made at one clock edge shows up in the fields, `pad_oe` and `pad_pu_dis` right after that edge. The bench therefore checks them at the falling edge that follows the write. A pin level reaches bit 4 only after two rising edges. The bench waits two full cycles before it compares readback with the modelled line level, and a directed case confirms that the old level is still there after one edge. The line level is modelled as a pull-up that is overridden by the block's pull-low or by a target holding the line.

// File: rtl/odpad_pkg.sv
package odpad_pkg;
  // Layout of one line's group inside the register word
  localparam int GRP_W    = 8;
  localparam int B_DIR_WE = 0;
  localparam int B_DIR    = 1;
  localparam int B_VAL_WE = 2;
  localparam int B_VAL    = 3;
  localparam int B_IN     = 4;
  localparam int B_PU_DIS = 5;

  typedef struct packed {
    logic dir_out;  // 1 = output
    logic val;      // output value when driven
    logic pu_dis;   // pull-up disable
  } pad_cfg_t;
endpackage

// File: rtl/odpad_field.sv
module odpad_field
  import odpad_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wr_en,
  input  logic     dir_we,
  input  logic     dir_d,
  input  logic     val_we,
  input  logic     val_d,
  input  logic     pu_d,
  output pad_cfg_t cfg,
  output logic     oe
);
  pad_cfg_t cfg_nxt;

  always_comb begin
    cfg_nxt = cfg;
    if (wr_en) begin
      if (dir_we) cfg_nxt.dir_out = dir_d;
      if (val_we) cfg_nxt.val     = val_d;
      cfg_nxt.pu_dis = pu_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
      oe  <= 1'b0;
    end else begin
      cfg <= cfg_nxt;
      oe  <= cfg_nxt.dir_out & ~cfg_nxt.val;
    end
  end
endmodule

// File: rtl/odpad_sync.sv
module odpad_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/odpad_ctl.sv
module odpad_ctl #(
  parameter int LINES       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [LINES*odpad_pkg::GRP_W-1:0] wr_data,
  output logic [LINES*odpad_pkg::GRP_W-1:0] rd_data,
  input  logic [LINES-1:0]                 pad_in,
  output logic [LINES-1:0]                 pad_oe,
  output logic [LINES-1:0]                 pad_pu_dis
);
  import odpad_pkg::*;

  logic [LINES-1:0] unused_wr_bits;

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      localparam int O = g * GRP_W;
      pad_cfg_t         cfg;
      logic             lvl;
      logic [GRP_W-1:0] rd_grp;

      odpad_field u_field (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .dir_we (wr_data[O+B_DIR_WE]),
        .dir_d  (wr_data[O+B_DIR]),
        .val_we (wr_data[O+B_VAL_WE]),
        .val_d  (wr_data[O+B_VAL]),
        .pu_d   (wr_data[O+B_PU_DIS]),
        .cfg    (cfg),
        .oe     (pad_oe[g])
      );

      odpad_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in[g]),
        .q   (lvl)
      );

      always_comb begin
        rd_grp           = '0;
        rd_grp[B_DIR]    = cfg.dir_out;
        rd_grp[B_VAL]    = cfg.val;
        rd_grp[B_IN]     = lvl;
        rd_grp[B_PU_DIS] = cfg.pu_dis;
      end

      assign rd_data[O +: GRP_W] = rd_grp;
      assign pad_pu_dis[g]       = cfg.pu_dis;
      assign unused_wr_bits[g]   = ^{wr_data[O+B_IN], wr_data[O+GRP_W-1:O+B_PU_DIS+1]};
    end
  endgenerate
endmodule

// File: rtl/odpad_ctl_chk.sv
module odpad_ctl_chk #(
  parameter int LINES       = 2,
  parameter int SYNC_STAGES = 2
) (
  input logic                             clk,
  input logic                             rst,
  input logic                             wr_en,
  input logic [LINES*odpad_pkg::GRP_W-1:0] wr_data,
  input logic [LINES*odpad_pkg::GRP_W-1:0] rd_data,
  input logic [LINES-1:0]                 pad_in,
  input logic [LINES-1:0]                 pad_oe,
  input logic [LINES-1:0]                 pad_pu_dis
);
  import odpad_pkg::*;

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_chk
      localparam int O = g * GRP_W;

      // R4
      oe_match_chk: assert property (@(posedge clk) disable iff (rst)
        pad_oe[g] == (rd_data[O+B_DIR] && !rd_data[O+B_VAL]));
      // R2
      dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[O+B_DIR_WE]) |=> $stable(rd_data[O+B_DIR]));
      // R2
      dir_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[O+B_DIR_WE]) |=> rd_data[O+B_DIR] == $past(wr_data[O+B_DIR]));
      // R3
      val_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[O+B_VAL_WE]) |=> $stable(rd_data[O+B_VAL]));
      // R3
      val_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[O+B_VAL_WE]) |=> rd_data[O+B_VAL] == $past(wr_data[O+B_VAL]));
      // R6
      pu_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> pad_pu_dis[g] == $past(wr_data[O+B_PU_DIS]));
      // R7
      we_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_data[O+B_DIR_WE] && !rd_data[O+B_VAL_WE] && rd_data[O+GRP_W-1:O+B_PU_DIS+1] == '0);
      // R8
      idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(pad_oe[g]) && $stable(pad_pu_dis[g]));
      if (SYNC_STAGES == 2) begin : g_sync2
        // R5
        in_sync_chk: assert property (@(posedge clk) disable iff (rst)
          (since_rst == 2'd2) |-> rd_data[O+B_IN] == $past(pad_in[g], 2));
      end
    end
  endgenerate
endmodule

bind odpad_ctl odpad_ctl_chk #(.LINES(LINES), .SYNC_STAGES(SYNC_STAGES)) u_chk (.*);

// File: tb/odpad_ctl_tb.sv
module odpad_ctl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 2;
  localparam int GW = 8;
  localparam int W = LINES * GW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic [LINES-1:0] pad_in, pad_oe, pad_pu_dis;
  logic [LINES-1:0] tgt_hold = '0;

  int n_chk = 0;
  int n_fail = 0;

  // Model of the line levels: external pull-up, low if the block or the target pulls
  assign pad_in = ~(pad_oe | tgt_hold);

  odpad_ctl #(.LINES(LINES), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_pu_dis(pad_pu_dis)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Expected register contents
  logic [LINES-1:0] m_dir = '0, m_val = '0, m_pu = '0;

  function automatic logic [LINES-1:0] exp_oe();
    return m_dir & ~m_val;
  endfunction

  function automatic logic [W-1:0] exp_word(input logic with_in);
    logic [W-1:0] w = '0;
    logic [LINES-1:0] lvl = ~(exp_oe() | tgt_hold);
    for (int i = 0; i < LINES; i++) begin
      w[i*GW+1] = m_dir[i];
      w[i*GW+3] = m_val[i];
      w[i*GW+5] = m_pu[i];
      if (with_in) w[i*GW+4] = lvl[i];
    end
    return w;
  endfunction

  function automatic logic [W-1:0] field_mask();
    logic [W-1:0] m = '1;
    for (int i = 0; i < LINES; i++) m[i*GW+4] = 1'b0;
    return m;
  endfunction

  function automatic logic [7:0] grp(input logic dwe, input logic d, input logic vwe,
                                     input logic v, input logic pu);
    return {2'b00, pu, 1'b0, v, vwe, d, dwe};
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_write(input logic [W-1:0] d);
    for (int i = 0; i < LINES; i++) begin
      if (d[i*GW+0]) m_dir[i] = d[i*GW+1];
      if (d[i*GW+2]) m_val[i] = d[i*GW+3];
      m_pu[i] = d[i*GW+5];
    end
  endtask

  // Write at a rising edge, check fields right after it, then the pin level two edges later
  task automatic wr(input string req, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = ~d;
    model_write(d);
    chk({req, " fields"}, rd_data & field_mask(), exp_word(1'b0));
    chk({req, " R4 oe"}, W'(pad_oe), W'(exp_oe()));
    chk({req, " R6 pu"}, W'(pad_pu_dis), W'(m_pu));
    repeat (2) @(negedge clk);
    chk({req, " R5 level"}, rd_data, exp_word(1'b1));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    tgt_hold = '1;  // pins low during reset so that readback is all zero
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd_data", rd_data, '0);
    chk("R1 pad_oe", W'(pad_oe), '0);
    chk("R1 pad_pu_dis", W'(pad_pu_dis), '0);
    tgt_hold = '0;
    repeat (2) @(negedge clk);
    chk("R5 released lines read high", rd_data, exp_word(1'b1));

    // R4 release clock, pull data low
    wr("R2 release clock", {grp(0,0,0,0,0), grp(1,0,0,0,0)});
    wr("R4 data low", {grp(1,1,1,0,0), grp(0,0,0,0,0)});
    chk("R4 data pulled", W'(pad_oe), W'(2'b10));
    // R2 R3 masked isolation: fields written with masks clear do not move
    wr("R2 R3 masks clear", {grp(0,0,0,1,0), grp(0,1,0,1,0)});
    chk("R2 R3 isolation oe", W'(pad_oe), W'(2'b10));
    // R3 value only
    wr("R3 value only", {grp(0,0,1,1,0), grp(0,0,1,0,0)});
    // R7 read-only bit and reserved bits ignored on write
    wr("R5 R7 ro bits", 16'hD0D0 | {grp(1,1,1,0,0), grp(1,1,1,1,0)});
    // R6 pull-up disables sticky to written value
    wr("R6 pu set", {grp(0,0,0,0,1), grp(0,0,0,0,1)});
    chk("R6 pu both", W'(pad_pu_dis), W'(2'b11));
    wr("R6 pu clear", {grp(0,0,0,0,0), grp(0,0,0,0,1)});

    // R5 target holds released data line low; readback follows the line
    wr("R5 release data", {grp(1,0,1,1,0), grp(1,0,0,0,0)});
    @(negedge clk);
    tgt_hold = 2'b10;
    @(negedge clk);
    chk("R5 one edge old level", W'(rd_data[GW+4]), W'(1'b1));
    @(negedge clk);
    chk("R5 two edges new level", W'(rd_data[GW+4]), W'(1'b0));
    tgt_hold = '0;
    repeat (2) @(negedge clk);

    // R8 data on the bus without strobe
    @(negedge clk);
    wr_data = {grp(1,1,1,0,1), grp(1,1,1,0,1)};
    repeat (3) @(negedge clk);
    chk("R8 fields held", rd_data & field_mask(), exp_word(1'b0));
    chk("R8 oe held", W'(pad_oe), W'(exp_oe()));

    // Random writes with random target activity
    for (int k = 0; k < 80; k++) begin
      tgt_hold = LINES'($urandom);
      wr("R2 R3 R4 R6 random", W'($urandom) & 16'h2F2F);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule